// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a synthesizable model of a single-ported synchronous static memory. It accepts one operation on every enabled clock edge, read or write in any mix, with no idle cycles between them. Every operation has the same pipeline shape. Address and control are captured on an edge. Two edges later the operation owns a one-cycle data slot. For a read, the output register presents the word during that slot. For a write, the controller drives the word during that slot, and the block captures it on the edge that closes the slot.

The data bus is 36 bits wide and split into four 9-bit lanes, and each lane has its own write select. The bidirectional bus is split into a write-data input, a read-data output and a drive-enable output. The drive enable is high only in the slot of a read, and an asynchronous output-enable pin can force it low at any time.

Three chip-select pins must all be active for an operation to take place. A clock-enable pin stalls the whole pipeline. A read that follows a still-pending write to the same word sees the new lanes merged over the old ones. The depth is set by an address-width parameter.

Top module: `nbsram`

## Requirements
- R1: While reset is held, and on the first cycle after it, `rdDrive` is 0 and `rdData` is all zeros.
- R2: A selected read sampled on enabled edge k loads `rdData` on enabled edge k+2 with the stored word. `rdDrive` is then 1 (if `outEnN` is 0) until the next enabled edge.
- R3: A selected write sampled on enabled edge k captures `wrData` on enabled edge k+3, which is the edge that ends its data slot.
- R4: On a write, `laneSelN[i]` = 0 updates bits [9i+8:9i] of the word. A lane whose select is 1 keeps its old contents.
- R5: When `wrN` is 1 the operation is a read, whatever `laneSelN` holds. A write with `laneSelN` = 4'b1111 changes no stored bit.
- R6: An operation is selected only when `csAN`=0, `csB`=1 and `csCN`=0. Any other combination is a deselect: nothing is stored and `rdDrive` stays 0 in its slot.
- R7: Reads and writes run back-to-back in any order. A read of a word whose write is still pending returns the written lanes merged over the stored lanes.
- R8: An edge with `clkEnN`=1 changes no state: no pipeline stage, no stored word, no `rdData`. The inputs on that edge are ignored, and the current slot is extended by one cycle.
- R9: `outEnN`=1 forces `rdDrive` to 0 combinationally. `rdDrive` is never 1 during a write or deselect slot.
- R10: In the slot of a write or a deselect, `rdData` keeps the value of the last read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Word address |
| wrData | input | 36 | Write data, driven during the write's data slot |
| wrN | input | 1 | Write enable, active low; high means read |
| laneSelN | input | 4 | Per-lane write selects, active low |
| csAN | input | 1 | Chip select A, active low |
| csB | input | 1 | Chip select B, active high |
| csCN | input | 1 | Chip select C, active low |
| clkEnN | input | 1 | Clock enable, active low; high stalls |
| outEnN | input | 1 | Asynchronous output enable, active low |
| rdData | output | 36 | Registered read data |
| rdDrive | output | 1 | Bus drive enable for read data |

## Verification
The checker evaluates several properties on every cycle:
- `rdDrive` follows a read two enabled edges after issue, and is forced low by `outEnN`.
- `rdData` is frozen across stalled edges.
- `rdData` changes only on an enabled edge that closes a read's pipeline.
- The state on leaving reset is correct.

Stored contents cannot be checked that way, so the bench's scenarios cover them:
- lane merging for all sixteen select patterns;
- forwarding from a pending write;
- deselects that must not write;
- stalls that must drop the inputs presented during them.

// File: rtl/nbsram_pkg.sv
package nbsram_pkg;

  localparam int NUM_LANES = 4;

  // Operation carried down the pipeline
  typedef struct packed {
    logic                 valid;
    logic                 write;
    logic [NUM_LANES-1:0] lanes;
  } slotCtl_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 commit;
    logic [NUM_LANES-1:0] commitLanes;
    logic                 load;
    logic [NUM_LANES-1:0] fwdLanes;
    logic                 drive;
  } strobe_t;

endpackage

// File: rtl/nbsram_ctrl.sv
module nbsram_ctrl
  import nbsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wrN,
  input  logic [NUM_LANES-1:0] laneSelN,
  input  logic                 csAN,
  input  logic                 csB,
  input  logic                 csCN,
  input  logic                 clkEnN,
  input  logic                 outEnN,
  output strobe_t              strobe,
  output logic [ADDR_W-1:0]    rdAddr,
  output logic [ADDR_W-1:0]    wrAddr
);

  localparam int STAGES = 3;
  localparam int RD_STG = STAGES - 2;  // read loads output register leaving this stage
  localparam int WR_STG = STAGES - 1;  // data slot stage

  slotCtl_t          stg     [STAGES];
  logic [ADDR_W-1:0] stgAddr [STAGES];
  slotCtl_t          incoming;
  logic              chipSel;
  logic              advance;
  logic              pendWrite;

  always_comb begin
    chipSel        = !csAN && csB && !csCN;
    advance        = !clkEnN;
    incoming.valid = chipSel;
    incoming.write = !wrN;
    incoming.lanes = ~laneSelN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin
        stg[i]     <= '0;
        stgAddr[i] <= '0;
      end
    end else if (advance) begin
      stg[0]     <= incoming;
      stgAddr[0] <= addr;
      for (int i = 1; i < STAGES; i++) begin
        stg[i]     <= stg[i-1];
        stgAddr[i] <= stgAddr[i-1];
      end
    end
  end

  always_comb begin
    pendWrite          = stg[WR_STG].valid && stg[WR_STG].write;
    rdAddr             = stgAddr[RD_STG];
    wrAddr             = stgAddr[WR_STG];
    strobe.commit      = advance && pendWrite;
    strobe.commitLanes = stg[WR_STG].lanes;
    strobe.load        = advance && stg[RD_STG].valid && !stg[RD_STG].write;
    strobe.fwdLanes    = (pendWrite && (stgAddr[WR_STG] == stgAddr[RD_STG]))
                         ? stg[WR_STG].lanes : '0;
    strobe.drive       = stg[WR_STG].valid && !stg[WR_STG].write && !outEnN;
  end

endmodule

// File: rtl/nbsram_dpath.sv
module nbsram_dpath
  import nbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  strobe_t                       strobe,
  input  logic [ADDR_W-1:0]             rdAddr,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [NUM_LANES*LANE_W-1:0]   wrData,
  output logic [NUM_LANES*LANE_W-1:0]   rdData
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = NUM_LANES * LANE_W;

  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] outReg;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] inLane;

    assign inLane = wrData[g*LANE_W +: LANE_W];

    always_ff @(posedge clk) begin
      if (strobe.commit && strobe.commitLanes[g]) begin
        laneMem[wrAddr] <= inLane;
      end
    end

    // pending write in the slot wins over stored lane
    assign merged[g*LANE_W +: LANE_W] = strobe.fwdLanes[g] ? inLane : laneMem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outReg <= '0;
    end else if (strobe.load) begin
      outReg <= merged;
    end
  end

  assign rdData = outReg;

endmodule

// File: rtl/nbsram.sv
module nbsram
  import nbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NUM_LANES*LANE_W-1:0]  wrData,
  input  logic                         wrN,
  input  logic [NUM_LANES-1:0]         laneSelN,
  input  logic                         csAN,
  input  logic                         csB,
  input  logic                         csCN,
  input  logic                         clkEnN,
  input  logic                         outEnN,
  output logic [NUM_LANES*LANE_W-1:0]  rdData,
  output logic                         rdDrive
);

  strobe_t           strobe;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W-1:0] wrAddr;

  nbsram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wrN      (wrN),
    .laneSelN (laneSelN),
    .csAN     (csAN),
    .csB      (csB),
    .csCN     (csCN),
    .clkEnN   (clkEnN),
    .outEnN   (outEnN),
    .strobe   (strobe),
    .rdAddr   (rdAddr),
    .wrAddr   (wrAddr)
  );

  nbsram_dpath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_dpath (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .rdAddr (rdAddr),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdData (rdData)
  );

  assign rdDrive = strobe.drive;

endmodule

// File: rtl/nbsram_chk.sv
module nbsram_chk
  import nbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           addr,
  input logic                        wrN,
  input logic                        csAN,
  input logic                        csB,
  input logic                        csCN,
  input logic                        clkEnN,
  input logic                        outEnN,
  input logic [NUM_LANES*LANE_W-1:0] rdData,
  input logic                        rdDrive
);

  // Independent tracking of selected reads, shifted only on enabled edges
  logic [2:0] readTrack;
  logic       issueRead;

  assign issueRead = !csAN && csB && !csCN && wrN;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      readTrack <= '0;
    end else if (!clkEnN) begin
      readTrack <= {readTrack[1:0], issueRead};
    end
  end

  // R1
  reset_exit_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (rdData == '0 && !rdDrive));

  // R9
  oe_force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outEnN |-> !rdDrive);

  // R2 R6 R9
  read_slot_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdDrive == (readTrack[2] && !outEnN));

  // R8
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clkEnN |=> $stable(rdData));

  // R10
  out_change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdData) |-> $past(!clkEnN && readTrack[1]));

endmodule

bind nbsram nbsram_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .wrN     (wrN),
  .csAN    (csAN),
  .csB     (csB),
  .csCN    (csCN),
  .clkEnN  (clkEnN),
  .outEnN  (outEnN),
  .rdData  (rdData),
  .rdDrive (rdDrive)
);

// File: tb/nbsram_bench.sv
module nbsram_bench;

  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int LW    = 9;
  localparam int DW    = 4 * LW;
  localparam int K_NONE = 0, K_READ = 1, K_WRITE = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic          wrN = 1'b1;
  logic [3:0]    laneSelN = 4'hF;
  logic          csAN = 1'b1, csB = 1'b0, csCN = 1'b1;
  logic          clkEnN = 1'b0;
  logic          outEnN = 1'b0;
  logic [DW-1:0] rdData;
  logic          rdDrive;

  always #5 clk = ~clk;

  nbsram #(.ADDR_W(AW), .LANE_W(LW)) u_nbsram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wrData(wrData), .wrN(wrN),
    .laneSelN(laneSelN), .csAN(csAN), .csB(csB), .csCN(csCN),
    .clkEnN(clkEnN), .outEnN(outEnN), .rdData(rdData), .rdDrive(rdDrive)
  );

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] lastRead = '0;

  // operations issued on the last three enabled edges, [2] is in its data slot
  int            hKind  [3] = '{0, 0, 0};
  int            hAddr  [3] = '{0, 0, 0};
  logic [3:0]    hLanes [3] = '{4'h0, 4'h0, 4'h0};
  logic [DW-1:0] hData  [3] = '{'0, '0, '0};
  string         hTag   [3] = '{"", "", ""};

  function automatic logic [DW-1:0] pat(int a);
    return {4'(a + 3), 32'(a * 32'h9E3779B1)};
  endfunction

  task automatic check(logic [DW-1:0] act, logic [DW-1:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // kind: pins driven; cs: {csAN,csB,csCN}, 3'b010 selects
  task automatic step(int kind, int a, logic [3:0] lanes, logic [DW-1:0] data,
                      string tag, bit stall = 0, bit oeOff = 0, logic [2:0] cs = 3'b010);
    int effKind;
    @(negedge clk);
    outEnN = oeOff;
    wrData = (hKind[2] == K_WRITE) ? hData[2] : {4'hA, 32'h5A5A_C3C3};
    #1;
    if (hKind[2] == K_READ) begin
      check(DW'(rdDrive), DW'(!oeOff), oeOff ? "R9" : hTag[2]);
      check(rdData, model[hAddr[2]], hTag[2]);
      lastRead = model[hAddr[2]];
    end else begin
      check(DW'(rdDrive), DW'(0), (hKind[2] == K_WRITE) ? "R9" : "R6");
      check(rdData, lastRead, "R10");
    end
    clkEnN = stall;
    addr   = AW'(a);
    wrN    = (kind == K_WRITE) ? 1'b0 : 1'b1;
    laneSelN = ~lanes;
    {csAN, csB, csCN} = (kind == K_NONE) ? 3'b111 : cs;
    effKind = (cs == 3'b010) ? kind : K_NONE;
    @(posedge clk);
    if (!stall) begin
      if (hKind[2] == K_WRITE) begin
        for (int l = 0; l < 4; l++) begin
          if (hLanes[2][l]) model[hAddr[2]][l*LW +: LW] = hData[2][l*LW +: LW];
        end
      end
      for (int i = 2; i > 0; i--) begin
        hKind[i] = hKind[i-1]; hAddr[i] = hAddr[i-1]; hLanes[i] = hLanes[i-1];
        hData[i] = hData[i-1]; hTag[i] = hTag[i-1];
      end
      hKind[0] = effKind; hAddr[0] = a; hLanes[0] = lanes; hData[0] = data; hTag[0] = tag;
    end
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) step(K_NONE, 0, 4'h0, '0, "R10");
  endtask

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 'x;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(DW'(rdDrive), DW'(0), "R1");
    check(rdData, '0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(DW'(rdDrive), DW'(0), "R1");
    check(rdData, '0, "R1");

    // R3: fill every word with full-lane writes, back-to-back
    for (int a = 0; a < DEPTH; a++) step(K_WRITE, a, 4'hF, pat(a), "R3");
    flush();
    // R2, R5: read back; lane selects ignored on reads
    for (int a = 0; a < DEPTH; a++) step(K_READ, a, 4'(a), '0, "R2");
    flush();

    // R4, R5: every lane pattern, each read immediately after its write
    for (int m = 0; m < 16; m++) begin
      step(K_WRITE, m, 4'(m), ~pat(m + 40), (m == 0) ? "R5" : "R4");
      step(K_READ, m, 4'h0, '0, (m == 0) ? "R5" : "R4");
    end
    flush();
    for (int a = 0; a < DEPTH; a++) step(K_READ, a, 4'h0, '0, "R4");

    // R7: mixed back-to-back traffic over four words, partial lanes
    for (int i = 0; i < 16; i++) begin
      step(K_WRITE, i & 3, 4'((i % 15) + 1), pat(i * 7 + 100), "R7");
      step(K_READ, i & 3, 4'h0, '0, "R7");
      step(K_READ, (i + 1) & 3, 4'h0, '0, "R7");
    end
    flush();

    // R6: all chip-select combinations; only one may write or read
    for (int c = 0; c < 8; c++) begin
      step(K_WRITE, 5, 4'hF, pat(200 + c), "R6", 0, 0, 3'(c));
      step(K_READ, 9, 4'h0, '0, "R6", 0, 0, 3'(c));
    end
    flush();
    step(K_READ, 5, 4'h0, '0, "R6");
    step(K_READ, 9, 4'h0, '0, "R6");
    flush();

    // R8: stalls inside read and write slots, with stray inputs during stalls
    step(K_WRITE, 7, 4'h5, pat(300), "R8");
    step(K_READ, 7, 4'h0, '0, "R8");
    step(K_WRITE, 7, 4'hF, pat(301), "R8", 1);
    step(K_READ, 3, 4'h0, '0, "R8");
    step(K_WRITE, 3, 4'hF, pat(302), "R8", 1);
    step(K_WRITE, 3, 4'hF, pat(303), "R8", 1);
    step(K_READ, 7, 4'h0, '0, "R8");
    step(K_WRITE, 8, 4'hA, pat(304), "R8");
    step(K_NONE, 0, 4'h0, '0, "R8", 1);
    step(K_READ, 8, 4'h0, '0, "R8");
    step(K_NONE, 0, 4'h0, '0, "R8", 1);
    step(K_NONE, 0, 4'h0, '0, "R8", 1);
    flush();
    step(K_READ, 3, 4'h0, '0, "R8");
    step(K_READ, 7, 4'h0, '0, "R8");
    flush();

    // R9: output enable off in a read slot and in a write slot
    step(K_READ, 2, 4'h0, '0, "R9");
    step(K_WRITE, 2, 4'hF, pat(400), "R9");
    step(K_READ, 2, 4'h0, '0, "R9");
    step(K_NONE, 0, 4'h0, '0, "R9", 0, 1);
    step(K_NONE, 0, 4'h0, '0, "R9", 0, 1);
    step(K_NONE, 0, 4'h0, '0, "R9", 0, 0);
    flush();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule